// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four independent pulse-width modulated outputs from one input clock. Each channel has two stages of division. A prescaler turns the input clock into a tick enable. A period counter then steps on that tick. The output is high while the period counter is below a programmed high-duration value. A channel therefore repeats every (prescale+1)*(divider+1) input clock cycles.

Software programs the channels through a small 32-bit memory-mapped register file. The divider, high-duration and prescale values are written into staging registers, and the running counters do not see them. They are committed to the counters only when software writes a 1 to the channel's update bit. If the channel is running, the commit waits for the end of the current period, so no period is ever produced with mixed settings. If the channel is stopped, the commit takes effect at once. A separate enable bit starts and stops each channel. While a channel is stopped its output stays low and its counters stay at zero.

Top module: `pwm_quad`

## Requirements
- R1: Channel n (0..3) has word A at byte address 8*n and word B at 8*n+4 (address bits [1:0] ignored). Word A holds the divider in bits [15:0] and the high duration in bits [31:16]. Word B holds the prescale in bits [15:0], the update command in bit 30 and the enable in bit 31. Reads return the written divider, high duration, prescale and enable, with all other bits 0.
- R2: The update bit is a write-only command and always reads back as 0.
- R3: Writing word A, or writing word B with bit 30 clear, leaves the output waveform of a running channel unchanged.
- R4: A running channel has a period of (prescale+1)*(divider+1) clock cycles. Each period starts with the output high for high_duration*(prescale+1) cycles, and the output is low for the rest of the period.
- R5: A high duration of 0 keeps the output constantly low. A high duration of divider+1 or more keeps the output constantly high.
- R6: When the enable is cleared, the output is low from the second clock edge after the write onward. The counters return to zero.
- R7: An update written while the channel runs takes effect at the next period boundary. All later periods use the new settings.
- R8: An update written while the channel is stopped loads the settings at once. After the enable is then set, the output is still low one cycle later and takes its first-period level on the cycle after that.
- R9: Each channel's configuration and output are independent of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The bench targets the commit path. It writes a new divider and high duration without the update bit and expects the old waveform to continue. A design that let staging values leak into the counters would change the period there. The 0% and 100% duty ends are checked for steady levels, which catches an off-by-one high-duration compare. The bench also checks exactly when the first pulse appears after an enable that follows an update made while stopped. A design that deferred that update to a period boundary, or failed to clear the counters on disable, would start late or with a wrong first pulse. Update readback and per-channel independence are checked as well.

// File: rtl/pwm_quad_pkg.sv
// Shared constants and the per-channel configuration record for the PWM block.
package pwm_quad_pkg;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] pre;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_quad_regs.sv
// Register file: staging values, enables and one-cycle update pulses per channel.
// Assumes NUM_CH is a power of two of at least 2; address bits [1:0] are ignored.
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output pwm_cfg_t          cfg_o [NUM_CH],
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] upd_o
);
    localparam int IDX_W = $clog2(NUM_CH);

    logic [IDX_W-1:0] idx;
    logic             word_b;

    assign idx    = bus_addr[ADDR_W-1:3];
    assign word_b = bus_addr[2];

    // Capture staging fields and raise the update pulse on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= '0;
            upd_o <= '0;
            for (int i = 0; i < NUM_CH; i++) cfg_o[i] <= '0;
        end else begin
            upd_o <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_wr && idx == IDX_W'(i)) begin
                    if (word_b) begin
                        cfg_o[i].pre <= bus_wdata[CNT_W-1:0];
                        en_o[i]      <= bus_wdata[31];
                        upd_o[i]     <= bus_wdata[30];
                    end else begin
                        cfg_o[i].div <= bus_wdata[CNT_W-1:0];
                        cfg_o[i].hi  <= bus_wdata[31:16];
                    end
                end
            end
        end
    end

    // Read mux; the update command is never stored, so it reads as zero.
    always_comb begin
        if (word_b) bus_rdata = {en_o[idx], 15'b0, cfg_o[idx].pre};
        else        bus_rdata = {cfg_o[idx].hi, cfg_o[idx].div};
    end
endmodule

// File: rtl/pwm_quad_chan.sv
// One PWM channel: active settings, prescaler, period counter and compare.
// Assumes upd_i is a one-cycle pulse and cfg_i already holds the staged values when it arrives.
module pwm_quad_chan
    import pwm_quad_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  logic     upd_i,
    input  pwm_cfg_t cfg_i,
    output logic     pwm_o
);
    pwm_cfg_t         act;
    logic             pend;
    logic             running;
    logic [CNT_W-1:0] pre_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic             tick;
    logic             wrap;

    assign tick = (pre_cnt == act.pre);
    assign wrap = tick && (per_cnt == act.div);

    // Counter stepping, disable handling and shadow-to-active commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= '0;
            pend    <= 1'b0;
            running <= 1'b0;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else begin
            running <= en_i;
            if (!running) begin
                pre_cnt <= '0;
                per_cnt <= '0;
                if (upd_i || pend) begin
                    act  <= cfg_i;
                    pend <= 1'b0;
                end
            end else if (!en_i) begin
                pre_cnt <= '0;
                per_cnt <= '0;
                pend    <= pend | upd_i;
            end else begin
                pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
                if (wrap)      per_cnt <= '0;
                else if (tick) per_cnt <= per_cnt + 1'b1;
                if (wrap && (pend || upd_i)) begin
                    act  <= cfg_i;
                    pend <= 1'b0;
                end else if (upd_i) begin
                    pend <= 1'b1;
                end
            end
        end
    end

    // High while the period count is below the active high duration.
    assign pwm_o = running && (per_cnt < act.hi);
endmodule

// File: rtl/pwm_quad.sv
// Top level: register file plus one generated channel per output.
// Assumes a single clock domain and a bus that presents one write per strobe cycle.
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int ADDR_W = $clog2(NUM_CH) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    pwm_cfg_t          cfg_w [NUM_CH];
    logic [NUM_CH-1:0] en_w;
    logic [NUM_CH-1:0] upd_w;

    pwm_quad_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_o(cfg_w), .en_o(en_w), .upd_o(upd_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_quad_chan chan_i (
            .clk(clk), .rst_n(rst_n), .en_i(en_w[g]), .upd_i(upd_w[g]),
            .cfg_i(cfg_w[g]), .pwm_o(pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_quad_chk.sv
// Checker for the PWM block: bus readback rules and disabled-output behaviour.
module pwm_quad_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] en_vec
);
    assert_upd_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[2] |-> !bus_rdata[30]);

    assert_word_a_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[2]) |=>
            (!$stable(bus_addr) || bus_rdata == $past(bus_wdata)));

    assert_word_b_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[2]) |=>
            (!$stable(bus_addr) ||
             (bus_rdata[31] == $past(bus_wdata[31]) &&
              bus_rdata[15:0] == $past(bus_wdata[15:0]) &&
              bus_rdata[29:16] == 14'b0)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_vec[g] && !$past(en_vec[g])) |-> !pwm_out[g]);
    end
endmodule

bind pwm_quad pwm_quad_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
    .en_vec(en_w)
);

// File: tb/pwm_quad_tb.sv
module pwm_quad_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pwm_quad dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input bit b, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(ch * 8 + (b ? 4 : 0)); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input bit b, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(ch * 8 + (b ? 4 : 0));
        #1 d = bus_rdata;
    endtask

    task automatic cfg(input int ch, input int pre, input int dv, input int hi, input bit en, input bit upd);
        wr(ch, 1'b0, {16'(hi), 16'(dv)});
        wr(ch, 1'b1, {en, upd, 14'b0, 16'(pre)});
    endtask

    // Measure one full period starting at a rising edge of the output.
    task automatic measure(input int ch, output int hi_n, output int per_n);
        int g = 0;
        hi_n = 0; per_n = 0;
        while (pwm_out[ch] && g < 5000) begin @(negedge clk); g++; end
        while (!pwm_out[ch] && g < 5000) begin @(negedge clk); g++; end
        while (pwm_out[ch] && g < 5000) begin @(negedge clk); hi_n++; g++; end
        per_n = hi_n;
        while (!pwm_out[ch] && g < 5000) begin @(negedge clk); per_n++; g++; end
    endtask

    task automatic steady(input int ch, input bit lvl, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch] != lvl) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        @(negedge clk);
        check(pwm_out == 4'b0, "R6 reset outputs", pwm_out, 0);
        rd(1, 1'b0, d);
        check(d == 32'b0, "R1 reset word A", d, 0);
    endtask

    task automatic t_waveforms;
        int h, p;
        cfg(0, 2, 4, 3, 1'b1, 1'b1);
        cfg(1, 0, 9, 5, 1'b1, 1'b1);
        cfg(2, 1, 2, 7, 1'b1, 1'b1);
        cfg(3, 0, 5, 0, 1'b1, 1'b1);
        measure(0, h, p);
        check(p == 15, "R4 ch0 period", p, 15);
        check(h == 9, "R4 ch0 high", h, 9);
        measure(1, h, p);
        check(p == 10, "R4 ch1 period", p, 10);
        check(h == 5, "R4 ch1 high", h, 5);
        steady(2, 1'b1, 40, "R5 full duty");
        steady(3, 1'b0, 40, "R5 zero duty");
    endtask

    task automatic t_readback;
        logic [31:0] d;
        rd(0, 1'b0, d);
        check(d == {16'd3, 16'd4}, "R1 word A", d, {16'd3, 16'd4});
        rd(0, 1'b1, d);
        check(d == {1'b1, 15'b0, 16'd2}, "R1 word B", d, {1'b1, 15'b0, 16'd2});
        check(d[30] == 1'b0, "R2 update reads 0", d[30], 0);
    endtask

    task automatic t_staging;
        int h, p;
        wr(1, 1'b0, {16'd1, 16'd3});
        measure(1, h, p);
        check(p == 10 && h == 5, "R3 staged not applied", p * 100 + h, 1005);
        wr(1, 1'b1, {1'b1, 1'b0, 14'b0, 16'd0});
        measure(1, h, p);
        check(p == 10 && h == 5, "R3 no-update word B", p * 100 + h, 1005);
        wr(1, 1'b1, {1'b1, 1'b1, 14'b0, 16'd0});
        measure(1, h, p);
        measure(1, h, p);
        check(p == 4 && h == 1, "R7 update at boundary", p * 100 + h, 401);
    endtask

    task automatic t_disable;
        int h, p;
        wr(0, 1'b1, {1'b0, 1'b0, 14'b0, 16'd2});
        @(negedge clk);
        check(pwm_out[0] == 1'b0, "R6 low after disable", pwm_out[0], 0);
        steady(0, 1'b0, 40, "R6 stays low");
        measure(1, h, p);
        check(p == 4 && h == 1, "R9 ch1 unaffected", p * 100 + h, 401);
    endtask

    task automatic t_idle_update;
        int h, p;
        wr(3, 1'b1, 32'd0);
        cfg(3, 0, 1, 1, 1'b0, 1'b1);
        steady(3, 1'b0, 4, "R8 low while stopped");
        wr(3, 1'b1, {1'b1, 1'b0, 14'b0, 16'd0});
        check(pwm_out[3] == 1'b0, "R8 first cycle low", pwm_out[3], 0);
        @(negedge clk);
        check(pwm_out[3] == 1'b1, "R8 first pulse", pwm_out[3], 1);
        measure(3, h, p);
        check(p == 2 && h == 1, "R8 immediate settings", p * 100 + h, 201);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_waveforms();
        t_readback();
        t_staging();
        t_disable();
        t_idle_update();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule